// File: doc/BRIEF.md
# Two-Wire Debug Frame Engine

This block is the master side of a two-wire debug link. It always drives the clock wire. The data wire is bidirectional: the block drives it through an output and an output enable, and reads it back through an input. A requester hands the block one transaction at a time on a valid/ready port. The four transactions are address write, address read, data write and data read. The block then clocks out the whole serial frame by itself. At the end it pulses a done flag and, for reads, returns the byte that was received. A data transaction can stall while the target holds the data line low. If the target never raises it, the transaction gives up and reports a timeout.

The requester can also ask for a target reset, which is a single long low pulse on the clock wire. All timing is taken from one parameter: the number of system clock cycles in a microsecond. A strobe keeps the clock low for one microsecond and then high for one microsecond. A reset holds the clock low for 25 microseconds and then waits one microsecond before the block is ready again. The parameter must be chosen so that the strobe low time stays well under the five-microsecond limit at which the target sees a reset.

Top module: `twd_frame_engine`

## Requirements
- R1: Outside a reset, every clock low pulse lasts exactly US cycles, where US is the number of system cycles in one microsecond. Every strobe returns the clock high for at least US cycles before the next one starts.
- R2: A one-cycle pulse on `rst_req` while the engine is idle gives one clock low pulse of 25*US cycles, then US high cycles. After that, `rsp_done` pulses with `rsp_timeout` at 0, 25*US+US+2 cycles after the cycle in which `rst_req` was sampled.
- R3: Every frame begins with one strobe while the data line is released (`tw_dat_oe`=0). The next two strobes drive the transaction code, bit 0 first. The codes are 00 data read, 01 data write, 10 address read and 11 address write, taken from `req_op`.
- R4: A data frame (code bit 1 = 0) drives two further strobes with data 0 right after the code. An address frame has no such field.
- R5: A write drives the 8 bits of `req_data` on 8 strobes, bit 0 first. An address write is exactly 12 strobes: start, two code bits, eight address bits and a final strobe.
- R6: A read samples `tw_dat_i` after each of 8 strobes, bit 0 first. When the frame completes, the byte appears on `rsp_data` together with the `rsp_done` pulse.
- R7: A data frame has a wait phase with the data line released. It is one strobe per attempt, with a pause of US+1 high cycles between attempts, until `tw_dat_i` is sampled high. In a data write the wait phase follows the data byte. In a data read it comes before the data byte.
- R8: If 20 wait attempts in a row sample `tw_dat_i` low, the frame ends at once without a final strobe. `rsp_done` pulses with `rsp_timeout` at 1.
- R9: A completed frame ends with one strobe while the data line is released. `rsp_done` pulses N*(2*US+1) + (A-1)*(US+1) cycles after the accepting edge, where N is the number of strobes in the frame and A is the number of wait attempts (A is taken as 1 for address frames).
- R10: While idle, the clock is high and the data line is released. `req_ready` is high only in idle with no reset pending, and it drops in the cycle after a request is accepted.
- R11: A reset request that arrives during a frame does not disturb that frame. The reset pulse starts only after the frame's `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Engine can accept a transaction |
| req_op | input | 2 | Transaction code (00 data read, 01 data write, 10 address read, 11 address write) |
| req_data | input | 8 | Byte to send for write transactions |
| rst_req | input | 1 | One-cycle request for a target reset pulse |
| rsp_done | output | 1 | One-cycle pulse at the end of a frame or reset |
| rsp_data | output | 8 | Byte received by the last completed read |
| rsp_timeout | output | 1 | Marks a `rsp_done` that ended on wait timeout |
| tw_clk | output | 1 | Debug clock wire |
| tw_dat_o | output | 1 | Value driven on the data wire |
| tw_dat_oe | output | 1 | Drive enable for the data wire |
| tw_dat_i | input | 1 | Value read from the data wire |

## Verification
The latency of `rsp_done` depends only on the number of strobes, the number of wait attempts and US. The bench therefore counts system cycles from the accepting edge and compares the count with the R9 formula. For a reset it uses the fixed count from R2. A target model changes `tw_dat_i` only on rising edges of `tw_clk`, which is US cycles before the engine samples it, so every sampled bit is stable. The bench reads outputs on falling edges of the system clock. Clock low widths are counted in the same way and compared against US and 25*US.

// File: rtl/twd_pkg.sv
package twd_pkg;

  // transaction codes; the bit order is sent on the wire
  localparam logic [1:0] OP_DRD = 2'b00;
  localparam logic [1:0] OP_DWR = 2'b01;
  localparam logic [1:0] OP_ARD = 2'b10;
  localparam logic [1:0] OP_AWR = 2'b11;

  typedef enum logic [1:0] {TK_STROBE, TK_RESET, TK_GAP} tick_kind_e;

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} tick_phase_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_INS, ST_LEN, ST_TX, ST_WAIT,
    ST_GAP, ST_RX, ST_STOP, ST_RESET
  } seq_state_e;

endpackage

// File: rtl/twd_strobe_timer.sv
module twd_strobe_timer
  import twd_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int STB_LO = 125,
  parameter int STB_HI = 125,
  parameter int RST_LO = 3125,
  parameter int RST_HI = 125,
  parameter int GAP    = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  tick_kind_e kind,
  output logic       line_clk,
  output logic       done
);

  localparam logic [CNT_W-1:0] L_STB_LO = CNT_W'(STB_LO - 1);
  localparam logic [CNT_W-1:0] L_STB_HI = CNT_W'(STB_HI - 1);
  localparam logic [CNT_W-1:0] L_RST_LO = CNT_W'(RST_LO - 1);
  localparam logic [CNT_W-1:0] L_RST_HI = CNT_W'(RST_HI - 1);
  localparam logic [CNT_W-1:0] L_GAP    = CNT_W'(GAP - 1);

  tick_phase_e      ph_q, ph_d;
  tick_kind_e       kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmr_en;

  assign tmr_en = start || (ph_q != PH_IDLE);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        kind_d = kind;
        if (kind == TK_GAP) begin
          ph_d  = PH_HI;
          cnt_d = L_GAP;
        end else begin
          ph_d  = PH_LO;
          cnt_d = (kind == TK_RESET) ? L_RST_LO : L_STB_LO;
        end
      end
      PH_LO: if (cnt_q == '0) begin
        ph_d  = PH_HI;
        cnt_d = (kind_q == TK_RESET) ? L_RST_HI : L_STB_HI;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      PH_HI: if (cnt_q == '0) ph_d = PH_IDLE;
             else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= TK_STROBE;
    end else if (tmr_en) begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign line_clk = (ph_q != PH_LO);
  assign done     = (ph_q == PH_HI) && (cnt_q == '0);

  // low-run observer for the pulse-width check
  logic [CNT_W-1:0] lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lo_run_q <= '0;
    else if (!line_clk)  lo_run_q <= lo_run_q + 1'b1;
    else                 lo_run_q <= '0;
  end

  // R1: a strobe never keeps the line low past its window
  a_r1_strobe_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_clk && kind_q != TK_RESET) |-> (lo_run_q < CNT_W'(STB_LO)));

  // R2: a reset pulse never exceeds its window either
  a_r2_reset_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_clk && kind_q == TK_RESET) |-> (lo_run_q < CNT_W'(RST_LO)));

endmodule

// File: rtl/twd_frame_seq.sv
module twd_frame_seq
  import twd_pkg::*;
#(
  parameter int TRIES = 20,
  parameter int TRY_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [7:0] req_data,
  input  logic       rst_req,
  output logic       tick_start,
  output tick_kind_e tick_kind,
  input  logic       tick_done,
  input  logic       dat_i,
  output logic       dat_o,
  output logic       dat_oe,
  output logic       rsp_done,
  output logic [7:0] rsp_data,
  output logic       rsp_timeout
);

  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(TRIES - 1);

  seq_state_e       st_q, st_d;
  logic [1:0]       op_q, op_d;
  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bit_q, bit_d;
  logic [TRY_W-1:0] try_q, try_d;
  logic             iss_q, iss_d;
  logic             rpend_q, rpend_d;
  logic [7:0]       rdat_q, rdat_d;
  logic             done_q, to_q;
  logic             fin, fin_to, adv;

  assign req_ready  = (st_q == ST_IDLE) && !rpend_q;
  assign tick_start = (st_q != ST_IDLE) && !iss_q;
  assign adv        = tick_done || (st_q == ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_RESET: tick_kind = TK_RESET;
      ST_GAP:   tick_kind = TK_GAP;
      default:  tick_kind = TK_STROBE;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    try_d   = try_q;
    rdat_d  = rdat_q;
    fin     = 1'b0;
    fin_to  = 1'b0;
    rpend_d = rpend_q | rst_req;
    iss_d   = iss_q;
    if (tick_start) iss_d = 1'b1;
    if (tick_done)  iss_d = 1'b0;

    if (st_q == ST_IDLE) begin
      if (rpend_q) begin
        st_d    = ST_RESET;
        rpend_d = rst_req;
      end else if (req_valid) begin
        st_d  = ST_START;
        op_d  = req_op;
        sh_d  = req_data;
        bit_d = '0;
        try_d = '0;
      end
    end else if (tick_done) begin
      unique case (st_q)
        ST_START: st_d = ST_INS;
        ST_INS: begin
          bit_d = bit_q + 1'b1;
          if (bit_q[0]) begin
            bit_d = '0;
            if (!op_q[1])      st_d = ST_LEN;
            else if (op_q[0])  st_d = ST_TX;
            else               st_d = ST_RX;
          end
        end
        ST_LEN: begin
          bit_d = bit_q + 1'b1;
          if (bit_q[0]) begin
            bit_d = '0;
            st_d  = op_q[0] ? ST_TX : ST_WAIT;
          end
        end
        ST_TX: begin
          sh_d  = {1'b0, sh_q[7:1]};
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) st_d = (op_q == OP_AWR) ? ST_STOP : ST_WAIT;
        end
        ST_RX: begin
          sh_d  = {dat_i, sh_q[7:1]};
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) st_d = ST_STOP;
        end
        ST_WAIT: begin
          if (dat_i) begin
            st_d = op_q[0] ? ST_STOP : ST_RX;
          end else if (try_q == LAST_TRY) begin
            fin    = 1'b1;
            fin_to = 1'b1;
          end else begin
            try_d = try_q + 1'b1;
            st_d  = ST_GAP;
          end
        end
        ST_GAP:  st_d = ST_WAIT;
        ST_STOP: begin
          fin = 1'b1;
          if (!op_q[0]) rdat_d = sh_q;
        end
        ST_RESET: fin = 1'b1;
        default:  st_d = ST_IDLE;
      endcase
      if (fin) st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_DRD;
      sh_q   <= '0;
      bit_q  <= '0;
      try_q  <= '0;
      rdat_q <= '0;
    end else if (adv) begin
      st_q   <= st_d;
      op_q   <= op_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      try_q  <= try_d;
      rdat_q <= rdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q   <= 1'b0;
      rpend_q <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      iss_q   <= iss_d;
      rpend_q <= rpend_d;
      done_q  <= fin;
      to_q    <= fin_to;
    end
  end

  assign dat_oe      = (st_q == ST_INS) || (st_q == ST_LEN) || (st_q == ST_TX);
  assign dat_o       = (st_q == ST_INS) ? op_q[bit_q[0]] :
                       (st_q == ST_TX)  ? sh_q[0] : 1'b0;
  assign rsp_done    = done_q;
  assign rsp_timeout = to_q;
  assign rsp_data    = rdat_q;

  // R10: an accepted request makes the engine busy
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: a timeout is only ever flagged with a completion
  a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> rsp_done);

  // R11: a reset pulse only begins from idle, never mid-frame
  a_r11_reset_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESET && $past(st_q) != ST_RESET) |-> $past(st_q) == ST_IDLE);

endmodule

// File: rtl/twd_frame_engine.sv
module twd_frame_engine
  import twd_pkg::*;
#(
  parameter int CLK_MHZ    = 125,
  parameter int WAIT_TRIES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [7:0] req_data,
  input  logic       rst_req,
  output logic       rsp_done,
  output logic [7:0] rsp_data,
  output logic       rsp_timeout,
  output logic       tw_clk,
  output logic       tw_dat_o,
  output logic       tw_dat_oe,
  input  logic       tw_dat_i
);

  localparam int US     = CLK_MHZ;
  localparam int STB_LO = US;
  localparam int STB_HI = US;
  localparam int RST_LO = 25 * US;
  localparam int RST_HI = US;
  localparam int GAP    = US;
  localparam int CNT_W  = $clog2(RST_LO + 1);
  localparam int TRY_W  = $clog2(WAIT_TRIES + 1);

  // asynchronous assert, synchronous release
  logic rs_q1, rs_q2, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_ni = rs_q2;

  logic       tick_start, tick_done;
  tick_kind_e tick_kind;

  twd_strobe_timer #(
    .CNT_W (CNT_W),
    .STB_LO(STB_LO),
    .STB_HI(STB_HI),
    .RST_LO(RST_LO),
    .RST_HI(RST_HI),
    .GAP   (GAP)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_ni),
    .start   (tick_start),
    .kind    (tick_kind),
    .line_clk(tw_clk),
    .done    (tick_done)
  );

  twd_frame_seq #(
    .TRIES(WAIT_TRIES),
    .TRY_W(TRY_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_ni),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_data   (req_data),
    .rst_req    (rst_req),
    .tick_start (tick_start),
    .tick_kind  (tick_kind),
    .tick_done  (tick_done),
    .dat_i      (tw_dat_i),
    .dat_o      (tw_dat_o),
    .dat_oe     (tw_dat_oe),
    .rsp_done   (rsp_done),
    .rsp_data   (rsp_data),
    .rsp_timeout(rsp_timeout)
  );

  // R10: lines are parked whenever a request could be taken
  a_r10_idle_lines: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> (tw_clk && !tw_dat_oe));

endmodule

// File: tb/twd_frame_engine_tb.sv
module twd_frame_engine_tb;

  localparam int US     = 4;
  localparam int TRIES  = 20;
  localparam int RST_LO = 25 * US;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, rst_req;
  logic [1:0] req_op;
  logic [7:0] req_data;
  logic       rsp_done, rsp_timeout;
  logic [7:0] rsp_data;
  logic       tw_clk, tw_dat_o, tw_dat_oe, tw_dat_i;

  always #4 clk = ~clk;

  twd_frame_engine #(.CLK_MHZ(US), .WAIT_TRIES(TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rst_req(rst_req),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
    .tw_clk(tw_clk), .tw_dat_o(tw_dat_o), .tw_dat_oe(tw_dat_oe),
    .tw_dat_i(tw_dat_i)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target model
  logic [1:0] cur_op;
  logic [7:0] cur_rd;
  int         cur_w;
  int         ecnt;
  logic       rec_oe [64];
  logic       rec_d  [64];

  function automatic logic resp_bit(input int k);
    case (cur_op)
      2'b10: if (k >= 4 && k <= 11) return cur_rd[k-4];
      2'b00: begin
        if (k == 5 + cur_w) return 1'b1;
        if (k >= 6 + cur_w && k <= 13 + cur_w) return cur_rd[k-6-cur_w];
      end
      2'b01: if (k == 13 + cur_w) return 1'b1;
      default: ;
    endcase
    return 1'b0;
  endfunction

  always @(posedge tw_clk) begin
    ecnt = ecnt + 1;
    if (ecnt < 64) begin
      rec_oe[ecnt] = tw_dat_oe;
      rec_d[ecnt]  = tw_dat_o;
    end
    tw_dat_i <= resp_bit(ecnt);
  end

  // low pulse width monitor
  int lowcnt = 0, bad_pulse = 0, n_rst = 0;
  always @(negedge clk) begin
    if (rst_n && !tw_clk) lowcnt++;
    else if (lowcnt > 0) begin
      if (lowcnt == RST_LO) n_rst++;
      else if (lowcnt != US) bad_pulse++;
      lowcnt = 0;
    end
  end

  function automatic logic exp_oe(input logic [1:0] op, input int k);
    if (k == 2 || k == 3) return 1'b1;
    if (!op[1] && (k == 4 || k == 5)) return 1'b1;
    if (op == 2'b01 && k >= 6 && k <= 13) return 1'b1;
    if (op == 2'b11 && k >= 4 && k <= 11) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_d(input logic [1:0] op, input logic [7:0] d, input int k);
    if (k == 2 || k == 3) return op[k-2];
    if (op == 2'b01 && k >= 6 && k <= 13) return d[k-6];
    if (op == 2'b11 && k >= 4 && k <= 11) return d[k-4];
    return 1'b0;
  endfunction

  task automatic do_frame(input logic [1:0] op, input logic [7:0] d, input int w,
                          input logic [7:0] rd, input bit chk_idle);
    int acc, lat, strobes, exp_lat, wn, mism, bad0, rst0;
    bit to;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_op = op; cur_w = w; cur_rd = rd; ecnt = 0; tw_dat_i = 1'b0;
    bad0 = bad_pulse; rst0 = n_rst;
    req_valid = 1'b1; req_op = op; req_data = d;
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    lat = cyc - acc;
    to = !op[1] && (w > TRIES);
    wn = to ? TRIES : w;
    if (op[1])          strobes = 12;
    else if (op == 2'b00) strobes = to ? 5 + TRIES : 5 + w + 9;
    else                strobes = to ? 13 + TRIES : 13 + w + 1;
    exp_lat = strobes * (2 * US + 1) + (op[1] ? 0 : (wn - 1) * (US + 1));
    mism = 0;
    for (int k = 1; k <= strobes && k < 64; k++) begin
      if (rec_oe[k] !== exp_oe(op, k)) mism++;
      else if (rec_oe[k] && rec_d[k] !== exp_d(op, d, k)) mism++;
    end
    check(mism == 0, "R3 R4 R5 drive pattern", mism, 0);
    check(ecnt == strobes, to ? "R8 strobe count" : "R7 R9 strobe count", ecnt, strobes);
    check(rsp_timeout == to, "R8 timeout flag", int'(rsp_timeout), int'(to));
    check(lat == exp_lat, "R9 done latency", lat, exp_lat);
    check(bad_pulse == bad0, "R1 strobe low width", bad_pulse, bad0);
    check(n_rst == rst0, "R11 no reset pulse inside frame", n_rst, rst0);
    if (!op[0] && !to)
      check(rsp_data == rd, "R6 read byte", int'(rsp_data), int'(rd));
    if (chk_idle) begin
      @(negedge clk);
      check(req_ready && tw_clk && !tw_dat_oe, "R10 idle lines",
            int'({req_ready, tw_clk, tw_dat_oe}), 3'b110);
    end
  endtask

  task automatic wait_reset_done(input int rst0, input bit chk_lat);
    int acc, lat;
    acc = cyc;
    while (!rsp_done) @(negedge clk);
    lat = cyc - acc;
    if (chk_lat) check(lat == RST_LO + US + 2, "R2 reset latency", lat, RST_LO + US + 2);
    check(rsp_timeout == 1'b0, "R2 reset done without timeout", int'(rsp_timeout), 0);
    @(negedge clk);
    check(n_rst == rst0 + 1, "R2 reset low width", n_rst, rst0 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd11));
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_data = 8'h00;
    rst_req = 1'b0; tw_dat_i = 1'b0; ecnt = 0;
    cur_op = 2'b11; cur_w = 1; cur_rd = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && tw_clk && !tw_dat_oe && !rsp_done, "R10 reset state",
          int'({req_ready, tw_clk, tw_dat_oe, rsp_done}), 4'b1100);

    // directed frames
    do_frame(2'b11, 8'hB4, 1, 8'h00, 1'b1);
    do_frame(2'b10, 8'h00, 1, 8'h5A, 1'b1);
    do_frame(2'b01, 8'h81, 1, 8'h00, 1'b1);
    do_frame(2'b00, 8'h00, 3, 8'hC3, 1'b1);
    do_frame(2'b00, 8'h00, TRIES, 8'h3C, 1'b1);   // R7 last allowed attempt
    do_frame(2'b00, 8'h00, TRIES + 5, 8'h00, 1'b1); // R8 read timeout
    do_frame(2'b01, 8'h7E, TRIES + 1, 8'h00, 1'b1); // R8 write timeout

    // R2 reset from idle
    @(negedge clk);
    r0 = n_rst;
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    wait_reset_done(r0, 1'b1);

    // R11 reset raised mid-frame is held off
    r0 = n_rst;
    fork
      do_frame(2'b01, 8'h96, 2, 8'h00, 1'b0);
      begin
        repeat (40) @(negedge clk);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
      end
    join
    check(!req_ready, "R11 reset pending after frame", int'(req_ready), 0);
    @(negedge clk);
    wait_reset_done(r0, 1'b0);

    // random mix
    for (int i = 0; i < 16; i++) begin
      logic [1:0] op;
      logic [7:0] d, rd;
      int w;
      op = 2'($urandom % 4);
      d  = 8'($urandom % 256);
      rd = 8'($urandom % 256);
      w  = 1 + int'($urandom % 4);
      do_frame(op, d, w, rd, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule